// File: doc/BRIEF.md
# HART Transmit Character Serializer

This block turns queued bytes into the serial mark/space bit stream that an FSK modulator converts into a HART carrier. A writer pushes bytes into an internal FIFO and watches the fill level so that it can keep the queue topped up. The host raises `rts`. After a programmable turnaround, counted in bit times, the block raises `cts` and takes over the line. If bytes are already waiting at that moment, the first character's start bit goes out on the same cycle that `cts` rises. If the queue is empty, the line holds mark until a byte arrives. The next character then starts on the following bit boundary.

Each character is 11 bit times long: a start bit at 0, eight data bits sent LSB first, an odd parity bit and a stop bit at 1. The bit time is `baud_div + 1` system clocks. With a 1.2288 MHz clock, `baud_div = 1023` gives 1200 bit/s. Characters follow each other with no idle time while the queue holds data. If the queue runs dry at the end of a character while `rts` is still high, the line returns to mark and a sticky gap flag is set. When `rts` falls, the character in flight is finished, and `cts` drops only after its stop bit. Bytes still queued stay for the next burst. A write to a full queue is discarded and sets a sticky overflow flag.

The controller has four states:
- `ST_IDLE`: `cts` is low and the line is at mark. It moves to `ST_TURN` when `rts` is high.
- `ST_TURN`: this state counts turnaround ticks. It moves to `ST_IDLE` if `rts` falls. When the count expires on a tick, it moves to `ST_SHIFT` (queue not empty, byte loaded) or to `ST_MARK` (queue empty).
- `ST_MARK`: `cts` is high and the line is at mark. It moves to `ST_IDLE` when `rts` is low. On a tick with data queued, it moves to `ST_SHIFT`.
- `ST_SHIFT`: one character is being sent. On the tick that ends the stop bit, it goes to `ST_IDLE` if `rts` is low. Otherwise it reloads and stays in `ST_SHIFT` if data is queued, or goes to `ST_MARK` and flags a gap.

Top module: `hart_tx_serializer`

## Requirements
- R1: `cts` rises on the (`turn_bits`+1)-th bit tick after the controller leaves idle. The first tick comes `baud_div`+1 clocks after `rts` is sampled high, so `cts` rises (`turn_bits`+1)·(`baud_div`+1) clocks after the edge that samples `rts`.
- R2: If the queue is empty when `cts` rises, `tx_line` stays at 1 (mark) until a byte is queued. That byte's start bit begins on the next bit tick, at most `baud_div`+1 clocks after the byte is queued.
- R3: If the queue is non-empty when `cts` rises, `tx_line` shows the start bit (0) on the same clock that `cts` rises.
- R4: A character is 11 bits, and each bit lasts exactly `baud_div`+1 clocks. Bit 0 is the start bit (0). Bits 1..8 are data bits d0..d7. Bit 9 is the parity bit, which is 1 exactly when d has an even number of ones (odd parity). Bit 10 is the stop bit (1). While data is queued, characters follow each other with no extra bit times between them.
- R5: If the queue is empty when a stop bit ends and `rts` is high, `tx_line` returns to mark and `gap_err` is set and stays set. Pulsing `err_clr[0]` clears it. No gap is flagged when the burst ends because `rts` fell.
- R6: A write while `fifo_level` equals the depth is discarded and `fifo_level` does not change. The write sets `ovf_err`, which stays set until `err_clr[1]` is pulsed.
- R7: `fifo_level` equals the number of bytes held. It rises one clock after an accepted write and falls one clock after a character is loaded.
- R8: If `rts` falls during a character, that character completes, and `cts` stays high through its stop bit. `cts` falls and the line sits at mark right after the stop bit. Bytes left in the queue remain there and are sent in the next burst.
- R9: After reset, `cts` is 0, `tx_line` is 1, `fifo_level` is 0, and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write strobe for the byte queue |
| wr_data | input | 8 | Byte to queue |
| baud_div | input | DIV_W | Bit time in clocks, minus one |
| turn_bits | input | TURN_W | Turnaround in bit times, minus one |
| rts | input | 1 | Request to send |
| err_clr | input | 2 | Write-one-to-clear: bit 0 clears the gap flag, bit 1 clears the overflow flag |
| cts | output | 1 | Clear to send |
| tx_line | output | 1 | Serial bit to the modulator (1 = mark) |
| fifo_level | output | LVL_W | Bytes currently queued |
| gap_err | output | 1 | Sticky gap (underrun) flag |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The turnaround is swept over every value from zero to three with an empty queue. This separates the tick-count latency from the mark-hold behaviour and from the one-tick start delay of a late byte. A burst with a preloaded, full queue then carries all 256 byte values back to back while the writer tops the queue up. Every bit of every frame is compared at its expected clock, which exercises parity for every input and any slip in bit timing. The same burst also checks the overflow drop, `rts` falling mid-character with queued bytes kept, and the contrast between an `rts`-ended burst (no gap) and an underrun (gap).

// File: rtl/hart_tx_pkg.sv
package hart_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TURN,
        ST_MARK,
        ST_SHIFT
    } tx_state_e;

    localparam int CHAR_W           = 8;
    localparam int FRAME_BITS       = 11;
    localparam int DIV_1200_DEFAULT = 1023;   // 1200 bit/s from 1.2288 MHz

    // start(0) + data LSB first + odd parity + stop(1); bit 0 leaves first
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [CHAR_W-1:0] d);
        return {1'b1, ~(^d), d, 1'b0};
    endfunction
endpackage

// File: rtl/hart_tx_fifo.sv
module hart_tx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head_data,
    output logic [LVL_W-1:0] level_o,
    output logic             empty_o,
    output logic             full_o,
    input  logic             ovf_clr,
    output logic             ovf_err
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok;

    assign full_o    = (level_o == LVL_W'(DEPTH));
    assign empty_o   = (level_o == '0);
    assign push_ok   = push_req && !full_o;
    assign head_data = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_o <= '0;
            ovf_err <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop)     rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop})
                2'b10:   level_o <= level_o + 1'b1;
                2'b01:   level_o <= level_o - 1'b1;
                default: level_o <= level_o;
            endcase
            if (push_req && full_o) ovf_err <= 1'b1;
            else if (ovf_clr)       ovf_err <= 1'b0;
        end
    end

    p_full_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_req && !pop) |=> (level_o == $past(level_o)));
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !ovf_clr) |=> ovf_err);
    p_level_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= LVL_W'(DEPTH));
    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty_o);
endmodule

// File: rtl/hart_tx_baud.sv
module hart_tx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!en || tick) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    p_tick_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));
endmodule

// File: rtl/hart_tx_framer.sv
module hart_tx_framer
    import hart_tx_pkg::*;
#(
    parameter int TURN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rts,
    input  logic [TURN_W-1:0] turn_bits,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              pop,
    output logic              active,
    output logic              cts_o,
    output logic              line_o,
    input  logic              gap_clr,
    output logic              gap_err
);
    localparam int BIT_W = $clog2(FRAME_BITS + 1);

    tx_state_e             state_q, state_d;
    logic [TURN_W-1:0]     turn_cnt;
    logic [FRAME_BITS-1:0] sreg;
    logic [BIT_W-1:0]      bit_cnt;
    logic                  frame_end, load, gap_set;

    assign frame_end = (state_q == ST_SHIFT) && tick && (bit_cnt == BIT_W'(FRAME_BITS - 1));
    assign active    = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        gap_set = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rts) state_d = ST_TURN;
            end
            ST_TURN: begin
                if (!rts) state_d = ST_IDLE;
                else if (tick && turn_cnt == '0) begin
                    load    = !fifo_empty;
                    state_d = fifo_empty ? ST_MARK : ST_SHIFT;
                end
            end
            ST_MARK: begin
                if (!rts) state_d = ST_IDLE;
                else if (tick && !fifo_empty) begin
                    load    = 1'b1;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (frame_end) begin
                    if (!rts) state_d = ST_IDLE;
                    else if (!fifo_empty) load = 1'b1;
                    else begin
                        gap_set = 1'b1;
                        state_d = ST_MARK;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pop = load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            turn_cnt <= '0;
            sreg     <= '1;
            bit_cnt  <= '0;
            line_o   <= 1'b1;
            cts_o    <= 1'b0;
            gap_err  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE)          turn_cnt <= turn_bits;
            else if (state_q == ST_TURN && tick) turn_cnt <= turn_cnt - 1'b1;

            if (load) begin
                sreg    <= build_frame(fifo_data);
                line_o  <= 1'b0;
                bit_cnt <= '0;
            end else if (state_q == ST_SHIFT && tick) begin
                sreg    <= {1'b1, sreg[FRAME_BITS-1:1]};
                line_o  <= sreg[1];
                bit_cnt <= bit_cnt + 1'b1;
            end else if (state_q != ST_SHIFT) begin
                line_o  <= 1'b1;
            end

            cts_o <= (state_d == ST_MARK) || (state_d == ST_SHIFT);

            if (gap_set)      gap_err <= 1'b1;
            else if (gap_clr) gap_err <= 1'b0;
        end
    end

    p_start_with_cts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cts_o) && !$past(fifo_empty)) |-> !line_o);
    p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !tick) |=> $stable(line_o));
    p_gap_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_err && !gap_clr) |=> gap_err);
    p_drop_after_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cts_o) |-> $past(line_o));
    p_mark_without_cts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cts_o |-> line_o);
endmodule

// File: rtl/hart_tx_serializer.sv
module hart_tx_serializer
    import hart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int DIV_W      = 16,
    parameter int TURN_W     = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic [TURN_W-1:0] turn_bits,
    input  logic              rts,
    input  logic [1:0]        err_clr,
    output logic              cts,
    output logic              tx_line,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              gap_err,
    output logic              ovf_err
);
    logic              pop, empty, full, tick, active;
    logic [CHAR_W-1:0] head;

    hart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_valid),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head),
        .level_o   (fifo_level),
        .empty_o   (empty),
        .full_o    (full),
        .ovf_clr   (err_clr[1]),
        .ovf_err   (ovf_err)
    );

    hart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active),
        .div   (baud_div),
        .tick  (tick)
    );

    hart_tx_framer #(.TURN_W(TURN_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rts        (rts),
        .turn_bits  (turn_bits),
        .fifo_empty (empty),
        .fifo_data  (head),
        .pop        (pop),
        .active     (active),
        .cts_o      (cts),
        .line_o     (tx_line),
        .gap_clr    (err_clr[0]),
        .gap_err    (gap_err)
    );

    p_full_flag_consistent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !empty);
endmodule

// File: tb/hart_tx_serializer_tb.sv
module hart_tx_serializer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int DIVV       = 3;
    localparam int BT         = DIVV + 1;
    localparam int LW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = '0;
    logic [15:0]   baud_div = 16'(DIVV);
    logic [3:0]    turn_bits = '0;
    logic          rts = 1'b0;
    logic [1:0]    err_clr = '0;
    logic          cts, tx_line, gap_err, ovf_err;
    logic [LW-1:0] fifo_level;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hart_tx_serializer #(.FIFO_DEPTH(DEPTH), .DIV_W(16), .TURN_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .baud_div(baud_div), .turn_bits(turn_bits), .rts(rts), .err_clr(err_clr),
        .cts(cts), .tx_line(tx_line), .fifo_level(fifo_level),
        .gap_err(gap_err), .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [7:0] d, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (i == 9) return ($countones(d) % 2 == 0);
        return 1'b1;
    endfunction

    task automatic write_byte(input logic [7:0] d);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        err_clr = m;
        @(negedge clk);
        err_clr = '0;
    endtask

    // line is at bit 0 of the frame now; checks the remaining bits on schedule
    task automatic check_frame(input logic [7:0] d, input string req);
        chk(tx_line == 1'b0, req, tx_line, 0);
        for (int i = 1; i < 11; i++) begin
            repeat (BT) @(negedge clk);
            chk(tx_line == exp_bit(d, i), req, tx_line, exp_bit(d, i));
        end
    endtask

    task automatic wait_cts(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!cts && k < 400);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(cts == 1'b0, "R9 cts", cts, 0);
        chk(tx_line == 1'b1, "R9 line", tx_line, 1);
        chk(fifo_level == 0, "R9 level", fifo_level, 0);
        chk(!gap_err && !ovf_err, "R9 flags", {gap_err, ovf_err}, 0);

        // Sweep of turnaround with empty queue
        for (int n = 0; n < 4; n++) begin
            logic [7:0] d;
            d = 8'(n * 37 + 5);
            turn_bits = 4'(n);
            rts = 1'b1;
            wait_cts(k);
            chk(k == (n + 1) * BT + 1, "R1 turnaround", k, (n + 1) * BT + 1);
            for (int c = 0; c < 2 * BT; c++) begin
                chk(tx_line == 1'b1 && cts, "R2 mark hold", tx_line, 1);
                @(negedge clk);
            end
            write_byte(d);
            k = 0;
            while (tx_line && k < 3 * BT) begin
                @(negedge clk);
                k++;
            end
            chk(k <= BT, "R2 start delay", k, BT);
            check_frame(d, "R4 frame");
            repeat (BT) @(negedge clk);
            chk(tx_line == 1'b1, "R5 gap mark", tx_line, 1);
            chk(gap_err == 1'b1, "R5 gap set", gap_err, 1);
            pulse_clr(2'b01);
            chk(gap_err == 1'b0, "R5 gap clear", gap_err, 0);
            rts = 1'b0;
            @(negedge clk);
            chk(cts == 1'b0, "R8 drop from mark", cts, 0);
            repeat (3) @(negedge clk);
        end

        // Preload, overflow
        for (int b = 0; b < DEPTH; b++) write_byte(8'(b));
        chk(fifo_level == DEPTH, "R7 level full", fifo_level, DEPTH);
        write_byte(8'hEE);
        chk(fifo_level == DEPTH, "R6 drop keeps level", fifo_level, DEPTH);
        chk(ovf_err == 1'b1, "R6 ovf set", ovf_err, 1);
        pulse_clr(2'b10);
        chk(ovf_err == 1'b0, "R6 ovf clear", ovf_err, 0);

        // Exhaustive byte burst
        turn_bits = 4'd1;
        rts = 1'b1;
        wait_cts(k);
        chk(k == 2 * BT + 1, "R1 turnaround preload", k, 2 * BT + 1);
        chk(tx_line == 1'b0, "R3 start with cts", tx_line, 0);
        fork
            begin
                for (int b = DEPTH; b < 258; b++) begin
                    while (fifo_level >= DEPTH) @(negedge clk);
                    write_byte(b < 256 ? 8'(b) : (b == 256 ? 8'hA5 : 8'h5A));
                end
            end
            begin
                for (int c = 0; c < 256; c++) begin
                    for (int i = 0; i < 11; i++) begin
                        if (!(c == 0 && i == 0)) repeat (BT) @(negedge clk);
                        chk(tx_line == exp_bit(8'(c), i), "R4 burst bit", tx_line, exp_bit(8'(c), i));
                        if (c == 255) begin
                            chk(cts == 1'b1, "R8 cts held", cts, 1);
                            if (i == 5) rts = 1'b0;
                        end
                    end
                end
            end
        join
        repeat (BT) @(negedge clk);
        chk(cts == 1'b0, "R8 cts drop", cts, 0);
        chk(tx_line == 1'b1, "R8 line mark", tx_line, 1);
        chk(gap_err == 1'b0, "R5 no gap on rts end", gap_err, 0);
        chk(fifo_level == 2, "R8 bytes kept", fifo_level, 2);

        // Kept bytes go out in next burst
        turn_bits = 4'd0;
        rts = 1'b1;
        wait_cts(k);
        chk(k == BT + 1, "R1 zero turnaround", k, BT + 1);
        check_frame(8'hA5, "R8 kept byte 1");
        repeat (BT) @(negedge clk);
        check_frame(8'h5A, "R8 kept byte 2");
        chk(fifo_level == 0, "R7 level drained", fifo_level, 0);
        repeat (BT) @(negedge clk);
        chk(gap_err == 1'b1, "R5 gap after drain", gap_err, 1);
        chk(tx_line == 1'b1, "R5 mark after drain", tx_line, 1);
        rts = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule